// File: doc/BRIEF.md
# Endpoint Receive Buffer Readout Port

This block lets a CPU drain received OUT packets from per-endpoint buffers of a USB device controller by programmed I/O. A byte-wide write port on the packet side fills one buffer per logical endpoint. Once the final byte of a packet is stored, that endpoint is marked as holding a ready packet. Software selects an endpoint and sets a read-enable bit in a control register. It then alternates reads of a length register, which gives the bytes left and a valid flag, with reads of a data register, which gives the next four bytes of the packet.

When the last word has been taken, the block drops read-enable and frees the buffer so that the next packet can land in it. The block also holds a max-packet-size value for each of 32 physical endpoints, reached through an index register and a size register.

The CPU side is a single-cycle register port. Read data is combinational for the presented address. Read side effects, such as advancing the pointer, and all writes take effect at the clock edge where the strobe is high. Register map (addr_i): 0 control, 1 receive data, 2 receive length, 3 endpoint index, 4 max packet size.

Top module: `usb_rx_readout`

## Requirements
- R1: After reset, the control, receive data, receive length and endpoint index registers all read 0.
- R2: Bytes presented on the write port are stored in order for wr_ep_i. The endpoint becomes ready after the byte with wr_last_i. The length register then reads bit 10 = 1 and bits 9:0 = packet byte count, provided control bit 0 (read enable) = 1 and control bits 4:1 select that endpoint.
- R3: Each data read returns the next four packet bytes little-endian. The earliest byte is in bits 7:0 and the latest in bits 31:24.
- R4: Each data read of a ready, enabled packet lowers the remaining count by 4, saturating at 0. Byte lanes at or past the packet end read as zero.
- R5: The data read that brings the remaining count to 0 clears control bit 0 and frees the buffer. The length register then reads 0, and a new packet written afterwards is accepted.
- R6: A data read while read enable is 0, or while the selected endpoint has no ready packet, returns 0 and leaves the read position and packet unchanged. With no ready packet the length register reads 0.
- R7: Bytes written to an endpoint that already holds a ready packet are ignored. Bytes beyond the 64-byte buffer capacity are dropped, and the length is capped at 64.
- R8: Writing the size register (addr 4, bits 9:0) stores the value for the physical endpoint named by the index register (addr 3, bits 4:0). Each of the 32 entries holds its own value and resets to 0.
- R9: Any write to the control register restarts reading of the selected packet at byte 0.
- R10: Buffers of different endpoints are independent, and packets can be drained in any endpoint order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Packet byte strobe |
| wr_ep_i | input | 4 | Logical endpoint of the byte |
| wr_byte_i | input | 8 | Packet byte |
| wr_last_i | input | 1 | Marks the final byte of a packet |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (enables read side effects) |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |

## Verification
The bench goes after packet lengths that are not a multiple of four, because a wrong pad would leak stale buffer bytes into the upper lanes of the final word. It checks the final read, where a wrong decision would either leave read enable set, so a zero-length valid state would linger, or never free the buffer, so the next packet would be lost. It covers reads issued before enabling and on empty endpoints, which a faulty design would let advance the pointer. It also covers writes into a full-packet buffer and 70-byte overruns, which would otherwise corrupt or lengthen the stored packet. Mid-packet control rewrites, cross-endpoint draining order and the full size array round out random packets of 1 to 64 bytes.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
  localparam int unsigned CNT_W     = 10;
  localparam int unsigned VALID_BIT = 10;

  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_DATA  = 3'd1,
    REG_PLEN  = 3'd2,
    REG_EPIDX = 3'd3,
    REG_MPS   = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/rx_buf_store.sv
module rx_buf_store
  import usb_rx_pkg::*;
#(
  parameter int unsigned NUM_EP    = 16,
  parameter int unsigned BUF_BYTES = 64,
  localparam int unsigned EP_W     = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [EP_W-1:0]   wr_ep_i,
  input  logic [7:0]        wr_byte_i,
  input  logic              wr_last_i,
  input  logic              rel_i,
  input  logic [EP_W-1:0]   rel_ep_i,
  input  logic [EP_W-1:0]   rd_ep_i,
  input  logic [CNT_W-1:0]  rd_ptr_i,
  output logic [NUM_EP-1:0] ready_o,
  output logic [CNT_W-1:0]  len_o,
  output logic [31:0]       word_o
);
  localparam int unsigned MEM_DEPTH = NUM_EP * BUF_BYTES;
  localparam int unsigned MEM_AW    = $clog2(MEM_DEPTH);

  logic [7:0]       mem_q [MEM_DEPTH];
  logic [CNT_W-1:0] cnt_q [NUM_EP];
  logic [NUM_EP-1:0] ready_q;
  logic             wr_accept;

  function automatic logic [MEM_AW-1:0] mem_addr(input logic [EP_W-1:0] ep,
                                                 input logic [CNT_W-1:0] off);
    return MEM_AW'(ep) * MEM_AW'(BUF_BYTES) + MEM_AW'(off);
  endfunction

  assign wr_accept = wr_valid_i && !ready_q[wr_ep_i] &&
                     (cnt_q[wr_ep_i] < CNT_W'(BUF_BYTES));

  always_ff @(posedge clk_i) begin
    if (wr_accept) mem_q[mem_addr(wr_ep_i, cnt_q[wr_ep_i])] <= wr_byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= '0;
      for (int e = 0; e < NUM_EP; e++) cnt_q[e] <= '0;
    end else begin
      for (int e = 0; e < NUM_EP; e++) begin
        if (rel_i && rel_ep_i == EP_W'(e)) begin
          cnt_q[e]   <= '0;
          ready_q[e] <= 1'b0;
        end else if (wr_valid_i && wr_ep_i == EP_W'(e) && !ready_q[e]) begin
          // bytes past capacity are dropped, the packet still completes
          if (cnt_q[e] < CNT_W'(BUF_BYTES)) cnt_q[e] <= cnt_q[e] + 1'b1;
          if (wr_last_i) ready_q[e] <= 1'b1;
        end
      end
    end
  end

  assign ready_o = ready_q;
  assign len_o   = cnt_q[rd_ep_i];

  always_comb begin
    word_o = '0;
    for (int k = 0; k < 4; k++) begin
      logic [CNT_W-1:0] off;
      off = rd_ptr_i + CNT_W'(k);
      if (off < len_o) word_o[8*k +: 8] = mem_q[mem_addr(rd_ep_i, off)];
    end
  end

  // R7
  len_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_o <= CNT_W'(BUF_BYTES));

  for (genvar e = 0; e < NUM_EP; e++) begin : g_chk
    // R2
    ready_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ready_q[e]) |-> $past(wr_valid_i && wr_last_i && (wr_ep_i == EP_W'(e))));
    // R7
    frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ready_q[e] && !(rel_i && rel_ep_i == EP_W'(e))) |=> $stable(cnt_q[e]));
  end
endmodule

// File: rtl/mps_array.sv
module mps_array #(
  parameter int unsigned NUM_PHY  = 32,
  parameter int unsigned MPS_W    = 10,
  localparam int unsigned IDX_W   = $clog2(NUM_PHY)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [MPS_W-1:0] wdata_i,
  output logic [MPS_W-1:0] rdata_o
);
  logic [MPS_W-1:0] mps_q [NUM_PHY];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PHY; p++) mps_q[p] <= '0;
    end else if (we_i) begin
      mps_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mps_q[idx_i];

  // R8
  mps_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rdata_o == $past(wdata_i)) || (idx_i != $past(idx_i)));
endmodule

// File: rtl/usb_rx_readout.sv
module usb_rx_readout
  import usb_rx_pkg::*;
#(
  parameter int unsigned NUM_EP     = 16,
  parameter int unsigned BUF_BYTES  = 64,
  parameter int unsigned NUM_PHY_EP = 32,
  localparam int unsigned EP_W      = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int unsigned PHY_W     = $clog2(NUM_PHY_EP)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_valid_i,
  input  logic [EP_W-1:0] wr_ep_i,
  input  logic [7:0]      wr_byte_i,
  input  logic            wr_last_i,
  input  logic            reg_we_i,
  input  logic            reg_re_i,
  input  logic [2:0]      reg_addr_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     reg_rdata_o
);
  reg_sel_e          sel;
  logic              rd_en_q;
  logic [EP_W-1:0]   log_ep_q;
  logic [CNT_W-1:0]  rd_ptr_q;
  logic [PHY_W-1:0]  ep_idx_q;
  logic [NUM_EP-1:0] ready_w;
  logic [CNT_W-1:0]  len_w;
  logic [CNT_W-1:0]  rem;
  logic [31:0]       word_w;
  logic [CNT_W-1:0]  mps_rd;
  logic              pkt_ok, data_rd, last_word, rel, ctrl_wr, mps_we;
  logic              unused_wdata;

  assign sel       = reg_sel_e'(reg_addr_i);
  assign pkt_ok    = rd_en_q && ready_w[log_ep_q];
  assign rem       = (len_w > rd_ptr_q) ? len_w - rd_ptr_q : '0;
  assign data_rd   = reg_re_i && !reg_we_i && sel == REG_DATA;
  assign last_word = rem <= CNT_W'(4);
  assign rel       = data_rd && pkt_ok && last_word;
  assign ctrl_wr   = reg_we_i && sel == REG_CTRL;
  assign mps_we    = reg_we_i && sel == REG_MPS;
  assign unused_wdata = ^reg_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_en_q  <= 1'b0;
      log_ep_q <= '0;
      rd_ptr_q <= '0;
      ep_idx_q <= '0;
    end else begin
      if (ctrl_wr) begin
        rd_en_q  <= reg_wdata_i[0];
        log_ep_q <= reg_wdata_i[EP_W:1];
        rd_ptr_q <= '0;
      end else if (data_rd && pkt_ok) begin
        if (last_word) begin
          rd_en_q  <= 1'b0;
          rd_ptr_q <= '0;
        end else begin
          rd_ptr_q <= rd_ptr_q + CNT_W'(4);
        end
      end
      if (reg_we_i && sel == REG_EPIDX) ep_idx_q <= reg_wdata_i[PHY_W-1:0];
    end
  end

  rx_buf_store #(.NUM_EP(NUM_EP), .BUF_BYTES(BUF_BYTES)) u_store (
    .clk_i, .rst_ni,
    .wr_valid_i, .wr_ep_i, .wr_byte_i, .wr_last_i,
    .rel_i    (rel),
    .rel_ep_i (log_ep_q),
    .rd_ep_i  (log_ep_q),
    .rd_ptr_i (rd_ptr_q),
    .ready_o  (ready_w),
    .len_o    (len_w),
    .word_o   (word_w)
  );

  mps_array #(.NUM_PHY(NUM_PHY_EP), .MPS_W(CNT_W)) u_mps (
    .clk_i, .rst_ni,
    .we_i    (mps_we),
    .idx_i   (ep_idx_q),
    .wdata_i (reg_wdata_i[CNT_W-1:0]),
    .rdata_o (mps_rd)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (sel)
      REG_CTRL:  reg_rdata_o = 32'({log_ep_q, rd_en_q});
      REG_DATA:  reg_rdata_o = pkt_ok ? word_w : '0;
      REG_PLEN: begin
        reg_rdata_o[VALID_BIT]   = pkt_ok;
        reg_rdata_o[CNT_W-1:0]   = pkt_ok ? rem : '0;
      end
      REG_EPIDX: reg_rdata_o = 32'(ep_idx_q);
      REG_MPS:   reg_rdata_o = 32'(mps_rd);
      default:   reg_rdata_o = '0;
    endcase
  end

  // R4
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && pkt_ok && !last_word) |=> (rem == $past(rem) - CNT_W'(4)) && rd_en_q);
  // R5
  drain_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel |=> !rd_en_q && !ready_w[$past(log_ep_q)]);
  // R6
  idle_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && !pkt_ok) |=> $stable(rd_ptr_q) && $stable(rd_en_q));
endmodule

// File: tb/usb_rx_readout_bench.sv
module usb_rx_readout_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NEP  = 16;
  localparam int CAP  = 64;
  localparam int NPHY = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [3:0]  wr_ep = '0;
  logic [7:0]  wr_byte = '0;
  logic        wr_last = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  usb_rx_readout u_usb_rx_readout (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_ep_i(wr_ep), .wr_byte_i(wr_byte), .wr_last_i(wr_last),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] pkt [NEP][CAP];
  int         plen_m [NEP];
  logic [9:0] mps_m [NPHY];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    #1 d = rdata;
    @(posedge clk); #1 re = 1'b0;
  endtask

  task automatic send_pkt(int ep, int len, bit keep);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      @(negedge clk);
      wr_valid = 1'b1; wr_ep = 4'(ep); wr_byte = b; wr_last = (i == len - 1);
      if (keep && i < CAP) pkt[ep][i] = b;
      @(posedge clk); #1 wr_valid = 1'b0; wr_last = 1'b0;
    end
    if (keep) plen_m[ep] = (len > CAP) ? CAP : len;
  endtask

  function automatic logic [31:0] exp_word(int ep, int ptr);
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++)
      if (ptr + k < plen_m[ep]) w[8*k +: 8] = pkt[ep][ptr + k];
    return w;
  endfunction

  task automatic drain(int ep, string req);
    logic [31:0] d;
    int rem, ptr;
    reg_wr(3'd0, 32'((ep << 1) | 1));
    rem = plen_m[ep]; ptr = 0;
    while (rem > 0) begin
      reg_rd(3'd2, d); chk(req, "plen", d, 32'((1 << 10) | rem));
      reg_rd(3'd1, d); chk("R3", "data word", d, exp_word(ep, ptr));
      ptr += 4;
      rem = (rem > 4) ? rem - 4 : 0;
    end
    reg_rd(3'd2, d); chk("R5", "plen after drain", d, 32'h0);
    reg_rd(3'd0, d); chk("R5", "ctrl after drain", d, 32'(ep << 1));
    plen_m[ep] = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4711));
    for (int e = 0; e < NEP; e++) plen_m[e] = 0;
    for (int p = 0; p < NPHY; p++) mps_m[p] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    reg_rd(3'd0, d); chk("R1", "ctrl", d, 0);
    reg_rd(3'd1, d); chk("R1", "data", d, 0);
    reg_rd(3'd2, d); chk("R1", "plen", d, 0);
    reg_rd(3'd3, d); chk("R1", "epidx", d, 0);

    // R6 reads before enable leave the packet intact
    send_pkt(3, 10, 1'b1);
    reg_wr(3'd0, 32'(3 << 1));
    reg_rd(3'd1, d); chk("R6", "data while disabled", d, 0);
    reg_rd(3'd1, d); chk("R6", "data while disabled 2", d, 0);
    reg_rd(3'd2, d); chk("R6", "plen while disabled", d, 0);
    reg_wr(3'd0, 32'((3 << 1) | 1));
    reg_rd(3'd2, d); chk("R2", "plen after enable", d, 32'((1 << 10) | 10));
    drain(3, "R4");

    // R5 freed buffer accepts a new packet
    send_pkt(3, 5, 1'b1);
    drain(3, "R5");

    // R6 enabled but empty endpoint
    reg_wr(3'd0, 32'((7 << 1) | 1));
    reg_rd(3'd1, d); chk("R6", "data empty ep", d, 0);
    reg_rd(3'd2, d); chk("R6", "plen empty ep", d, 0);

    // R7 write into a ready buffer ignored, overrun capped
    send_pkt(5, 4, 1'b1);
    send_pkt(5, 3, 1'b0);
    drain(5, "R7");
    send_pkt(6, 70, 1'b1);
    reg_wr(3'd0, 32'((6 << 1) | 1));
    reg_rd(3'd2, d); chk("R7", "plen capped", d, 32'((1 << 10) | CAP));
    drain(6, "R7");

    // R9 control rewrite restarts at byte 0
    send_pkt(2, 12, 1'b1);
    reg_wr(3'd0, 32'((2 << 1) | 1));
    reg_rd(3'd1, d); chk("R3", "first word", d, exp_word(2, 0));
    reg_rd(3'd2, d); chk("R4", "plen after one read", d, 32'((1 << 10) | 8));
    reg_wr(3'd0, 32'((2 << 1) | 1));
    reg_rd(3'd2, d); chk("R9", "plen after restart", d, 32'((1 << 10) | 12));
    reg_rd(3'd1, d); chk("R9", "word after restart", d, exp_word(2, 0));
    drain(2, "R9");

    // R10 independent endpoints, drained out of order
    send_pkt(1, 9, 1'b1);
    send_pkt(9, 17, 1'b1);
    drain(9, "R10");
    drain(1, "R10");

    // random packets
    for (int n = 0; n < 30; n++) begin
      int ep, len;
      ep  = int'($urandom % NEP);
      len = 1 + int'($urandom % CAP);
      send_pkt(ep, len, 1'b1);
      drain(ep, "R4");
    end

    // R8 size array
    for (int n = 0; n < 40; n++) begin
      int idx;
      logic [9:0] v;
      idx = (n == 0) ? 0 : (n == 1) ? 31 : int'($urandom % NPHY);
      v = 10'($urandom);
      reg_wr(3'd3, 32'(idx));
      reg_wr(3'd4, {$urandom} & 32'hFFFF_FC00 | 32'(v));
      mps_m[idx] = v;
    end
    for (int p = 0; p < NPHY; p++) begin
      reg_wr(3'd3, 32'(p));
      reg_rd(3'd4, d); chk("R8", $sformatf("mps[%0d]", p), d, 32'(mps_m[p]));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule